// File: doc/BRIEF.md
# Frame SPI Master with Word FIFOs

This block is an SPI master that moves one frame of 1 to 64 words per start command. Software talks to it over a small 32-bit register bus. Before a frame it loads up to 64 transmit words into a transmit FIFO. It then raises four enable bits in the control register: serial clock, receive, transmit and frame start. When the frame is over, it reads the received words back from a separate 64-word receive FIFO.

Words hold 8 to 32 bits and sit left-justified in the 32-bit FIFO data port. They shift MSB-first or LSB-first, in any of the four SPI clock modes. The shift rate comes from an input `tick` strobe, and each strobe moves the serial clock by one half period. Chip select is driven outside the block.

At the end of a frame the block raises transmit and receive end-of-frame flags. These flags can drive the interrupt output. For 3-wire buses, the data output can be released to high impedance while no frame is running.

Top module: `spi_frame_master`

## Requirements
- R1: After reset every register reads 0, `sck` is 0, `irq` is 0, `mosi_oe` is 1 and both FIFOs are empty.
- R2: Control bits 15 (serial clock), 14 (frame start), 9 (transmit) and 8 (receive) read back 1 one clock after the write that sets them, and not in the cycle straight after that write. A cleared bit keeps reading 1 until the running frame has ended, then reads 0.
- R3: A frame starts when frame start becomes active while clock and at least one of transmit/receive are active. The word length is (mode-2 bits [28:24])+1 bits and the word count is (bits [21:16])+1 words. The frame uses the transmit mode-2 copy when transmit is enabled, and the receive copy otherwise.
- R4: An N-bit word uses data-port bits [31:32-N]. A received word appears in the same bits with all lower bits 0.
- R5: Bits leave MSB-first. When bit 24 of the transmit mode-1 register is set, they leave LSB-first.
- R6: Control bit 30 is the idle clock level (CPOL). Bit 27 set with CPOL 0, or bit 27 clear with CPOL 1, gives phase 0: data is valid before the leading edge and sampled on it. The other two combinations launch data on the leading edge and sample it on the trailing edge.
- R7: With transmit mode-2 bit 0 set, the block shifts all-ones words and leaves the transmit FIFO untouched. An empty transmit FIFO, or transmit disabled, also gives all-ones.
- R8: At frame end, status bit 23 sets if transmit was enabled and status bit 7 sets if receive was enabled. Writing 1 to a status bit clears it.
- R9: `irq` is high while status bit 23 or bit 7 is set together with the same bit of the interrupt-enable register (address 6).
- R10: A data-port write to a full transmit FIFO is dropped and sets sticky status bit 17. A data-port read of an empty receive FIFO returns 0 and sets sticky status bit 1.
- R11: With control bits [23:22] = 10, `mosi_oe` is 0 whenever no frame is running. Otherwise it is 1.
- R12: Each FIFO holds 64 words and keeps them in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Half-period strobe for the serial clock |
| bus_addr | input | 3 | Register select: 0/1 transmit mode-1/2, 2/3 receive mode-1/2, 4 control, 5 status, 6 interrupt enable, 7 FIFO data port |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive FIFO at address 7) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rd` is high |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for `mosi` |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Interrupt request |

## Verification
The serial data output is looped back to the input. A bit-level slave model in the bench samples on the edge that the selected mode calls for. Frames are run in all four clock modes, with word lengths of 8, 12, 16 and 32 bits and both bit orders, so a wrong edge, a wrong bit index or a mis-justified word shows up as a bit-stream or read-back mismatch.

Further frames cover the no-data flag, receive-only operation and a full 64-word frame preceded by an overflow write, which separates filler generation, flag selection and FIFO ordering. A frame with the frame-start bit cleared mid-flight checks the delayed read-back and the 3-wire output release.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam int WORD_W = 32;
  localparam int BIT_W  = 5;
  localparam int CNT_W  = 6;

  localparam logic [2:0] A_TMODE1 = 3'd0;
  localparam logic [2:0] A_TMODE2 = 3'd1;
  localparam logic [2:0] A_RMODE1 = 3'd2;
  localparam logic [2:0] A_RMODE2 = 3'd3;
  localparam logic [2:0] A_CTRL   = 3'd4;
  localparam logic [2:0] A_STAT   = 3'd5;
  localparam logic [2:0] A_IEN    = 3'd6;
  localparam logic [2:0] A_DATA   = 3'd7;

  // data-port bit that carries serial bit idx of a word of nm1+1 bits
  function automatic logic [BIT_W-1:0] bit_pos(input logic lsb_first,
                                               input logic [BIT_W-1:0] nm1,
                                               input logic [BIT_W-1:0] idx);
    if (lsb_first) bit_pos = BIT_W'(5'd31 - nm1 + idx);
    else           bit_pos = BIT_W'(5'd31 - idx);
  endfunction

  // left-justified mask covering a word of nm1+1 bits
  function automatic logic [WORD_W-1:0] word_mask(input logic [BIT_W-1:0] nm1);
    word_mask = {WORD_W{1'b1}} << (5'd31 - nm1);
  endfunction
endpackage

// File: rtl/sfe_fifo.sv
module sfe_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;
  logic [AW:0]  fill;

  assign fill  = wp - rp;
  assign full  = (fill == (AW+1)'(DEPTH));
  assign empty = (fill == '0);
  assign dout  = mem[rp[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp[AW-1:0]] <= din;
  end
endmodule

// File: rtl/sfe_shifter.sv
module sfe_shifter
  import sfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic [BIT_W-1:0]  nm1,
  input  logic [CNT_W-1:0]  wm1,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              tx_have,
  input  logic              miso,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_word,
  output logic              busy,
  output logic              done,
  output logic              sck,
  output logic              mosi
);
  logic              run, half, sck_q, mosi_q;
  logic [BIT_W-1:0]  bidx;
  logic [CNT_W-1:0]  widx;
  logic [WORD_W-1:0] cur, rxw, next_word;
  logic [BIT_W-1:0]  pos;

  wire lead      = tick && run && !half;
  wire trail     = tick && run && half;
  wire last_bit  = (bidx == nm1);
  wire last_word = (widx == wm1);
  wire word_end  = trail && last_bit;
  wire load      = (start && !run) || (word_end && !last_word);

  assign pos       = bit_pos(lsb_first, nm1, bidx);
  assign next_word = tx_have ? tx_word : {WORD_W{1'b1}};
  assign tx_pop    = load && tx_have;
  assign rx_push   = word_end;
  assign done      = word_end && last_word;
  assign busy      = run;
  assign sck       = run ? sck_q : cpol;
  assign mosi      = mosi_q;

  always_comb begin
    rx_word = rxw;
    if (cpha && trail) rx_word[pos] = miso;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; half <= 1'b0; sck_q <= 1'b0; mosi_q <= 1'b0;
      bidx <= '0; widx <= '0; cur <= '0; rxw <= '0;
    end else begin
      if (start && !run) begin
        run <= 1'b1; half <= 1'b0; bidx <= '0; widx <= '0; sck_q <= cpol;
      end
      if (load) begin
        cur <= next_word;
        rxw <= '0;
        if (!cpha) mosi_q <= next_word[bit_pos(lsb_first, nm1, '0)];
      end
      if (lead) begin
        half  <= 1'b1;
        sck_q <= ~cpol;
        if (!cpha) rxw[pos] <= miso;
        else       mosi_q   <= cur[pos];
      end
      if (trail) begin
        half  <= 1'b0;
        sck_q <= cpol;
        if (cpha) rxw[pos] <= miso;
        if (!last_bit) begin
          bidx <= bidx + 1'b1;
          if (!cpha) mosi_q <= cur[bit_pos(lsb_first, nm1, bidx + 1'b1)];
        end else begin
          bidx <= '0;
          if (last_word) run <= 1'b0;
          else           widx <= widx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
  import sfe_pkg::*;
#(
  parameter int FIFO_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sck,
  output logic        mosi,
  output logic        mosi_oe,
  input  logic        miso,
  output logic        irq
);
  logic             tx_lsb, rx_lsb, tx_nodata;
  logic [BIT_W-1:0] tx_nm1, rx_nm1;
  logic [CNT_W-1:0] tx_wm1, rx_wm1;
  logic             cfg_tidle, cfg_ridle, cfg_tedg, cfg_redg;
  logic [1:0]       cfg_diz;
  logic             req_clk, req_fs, req_tx, req_rx;
  logic             act_clk, act_fs, act_tx, act_rx, fs_armed;
  logic             st_teof, st_reof, st_txovf, st_rxunf, ie_teof, ie_reof;

  logic [WORD_W-1:0] txf_dout, rxf_dout, eng_rx_word;
  logic txf_full, txf_empty, rxf_full, rxf_empty;
  logic eng_tx_pop, eng_rx_push, eng_busy, eng_done, eng_start, eng_cpha;
  logic unused_wdata;

  wire wr_data  = bus_wr && (bus_addr == A_DATA);
  wire rd_data  = bus_rd && (bus_addr == A_DATA);
  wire wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
  wire wr_stat  = bus_wr && (bus_addr == A_STAT);
  wire ovf_ev   = wr_data && txf_full;
  wire unf_ev   = rd_data && rxf_empty;
  wire tx_have  = act_tx && !tx_nodata && !txf_empty;

  assign unused_wdata = ^bus_wdata;
  assign eng_start = act_clk && act_fs && !fs_armed && (act_tx || act_rx);
  assign eng_cpha  = ~(cfg_tedg ^ cfg_tidle);
  assign mosi_oe   = !((cfg_diz == 2'b10) && !eng_busy);
  assign irq       = (st_teof && ie_teof) || (st_reof && ie_reof);

  sfe_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk, .rst_n, .push(wr_data), .din(bus_wdata), .pop(eng_tx_pop),
    .dout(txf_dout), .full(txf_full), .empty(txf_empty));

  sfe_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk, .rst_n, .push(eng_rx_push && act_rx), .din(eng_rx_word), .pop(rd_data),
    .dout(rxf_dout), .full(rxf_full), .empty(rxf_empty));

  sfe_shifter u_eng (
    .clk, .rst_n, .tick(tick && act_clk), .start(eng_start),
    .cpol(cfg_tidle), .cpha(eng_cpha), .lsb_first(tx_lsb),
    .nm1(act_tx ? tx_nm1 : rx_nm1), .wm1(act_tx ? tx_wm1 : rx_wm1),
    .tx_word(txf_dout), .tx_have, .miso,
    .tx_pop(eng_tx_pop), .rx_push(eng_rx_push), .rx_word(eng_rx_word),
    .busy(eng_busy), .done(eng_done), .sck, .mosi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_lsb <= 1'b0; rx_lsb <= 1'b0; tx_nodata <= 1'b0;
      tx_nm1 <= '0; rx_nm1 <= '0; tx_wm1 <= '0; rx_wm1 <= '0;
      cfg_tidle <= 1'b0; cfg_ridle <= 1'b0; cfg_tedg <= 1'b0; cfg_redg <= 1'b0;
      cfg_diz <= '0;
      req_clk <= 1'b0; req_fs <= 1'b0; req_tx <= 1'b0; req_rx <= 1'b0;
      act_clk <= 1'b0; act_fs <= 1'b0; act_tx <= 1'b0; act_rx <= 1'b0;
      fs_armed <= 1'b0;
      st_teof <= 1'b0; st_reof <= 1'b0; st_txovf <= 1'b0; st_rxunf <= 1'b0;
      ie_teof <= 1'b0; ie_reof <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_TMODE1) tx_lsb <= bus_wdata[24];
      if (bus_wr && bus_addr == A_RMODE1) rx_lsb <= bus_wdata[24];
      if (bus_wr && bus_addr == A_TMODE2) begin
        tx_nm1 <= bus_wdata[28:24]; tx_wm1 <= bus_wdata[21:16]; tx_nodata <= bus_wdata[0];
      end
      if (bus_wr && bus_addr == A_RMODE2) begin
        rx_nm1 <= bus_wdata[28:24]; rx_wm1 <= bus_wdata[21:16];
      end
      if (bus_wr && bus_addr == A_IEN) begin
        ie_teof <= bus_wdata[23]; ie_reof <= bus_wdata[7];
      end
      if (wr_ctrl) begin
        cfg_tidle <= bus_wdata[30]; cfg_ridle <= bus_wdata[28];
        cfg_tedg  <= bus_wdata[27]; cfg_redg  <= bus_wdata[26];
        cfg_diz   <= bus_wdata[23:22];
        req_clk <= bus_wdata[15]; req_fs <= bus_wdata[14];
        req_tx  <= bus_wdata[9];  req_rx <= bus_wdata[8];
      end
      act_clk  <= req_clk || (act_clk && eng_busy);
      act_fs   <= req_fs  || (act_fs  && eng_busy);
      act_tx   <= req_tx  || (act_tx  && eng_busy);
      act_rx   <= req_rx  || (act_rx  && eng_busy);
      fs_armed <= act_fs && (fs_armed || eng_start);
      st_teof  <= (st_teof  && !(wr_stat && bus_wdata[23])) || (eng_done && act_tx);
      st_reof  <= (st_reof  && !(wr_stat && bus_wdata[7]))  || (eng_done && act_rx);
      st_txovf <= (st_txovf && !(wr_stat && bus_wdata[17])) || ovf_ev;
      st_rxunf <= (st_rxunf && !(wr_stat && bus_wdata[1]))  || unf_ev;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        A_TMODE1: bus_rdata[24] = tx_lsb;
        A_RMODE1: bus_rdata[24] = rx_lsb;
        A_TMODE2: bus_rdata = {3'b0, tx_nm1, 2'b0, tx_wm1, 15'b0, tx_nodata};
        A_RMODE2: bus_rdata = {3'b0, rx_nm1, 2'b0, rx_wm1, 16'b0};
        A_CTRL:   bus_rdata = {1'b0, cfg_tidle, 1'b0, cfg_ridle, cfg_tedg, cfg_redg,
                               2'b0, cfg_diz, 6'b0, act_clk, act_fs, 4'b0,
                               act_tx, act_rx, 8'b0};
        A_STAT:   bus_rdata = {8'b0, st_teof, 5'b0, st_txovf, 9'b0, st_reof, 5'b0,
                               st_rxunf, 1'b0};
        A_IEN:    bus_rdata = {8'b0, ie_teof, 15'b0, ie_reof, 7'b0};
        default:  bus_rdata = rxf_empty ? '0 : rxf_dout;
      endcase
    end
  end
endmodule

// File: rtl/sfe_checker.sv
module sfe_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       sck,
  input logic       cpol,
  input logic       done,
  input logic       act_tx,
  input logic       act_rx,
  input logic       st_teof,
  input logic       st_reof,
  input logic       req_clk,
  input logic       act_clk,
  input logic       tx_pop,
  input logic       tx_empty,
  input logic       rx_push_ok,
  input logic       rx_full
);
  p_ctrl_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_clk) |-> $past(req_clk));
  p_sck_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == cpol));
  p_teof_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && act_tx) |=> st_teof);
  p_reof_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && act_rx) |=> st_reof);
  p_no_underrun_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);
  p_rx_room_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push_ok && rx_full) |=> rx_full);
endmodule

bind spi_frame_master sfe_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(eng_busy), .sck(sck), .cpol(cfg_tidle),
  .done(eng_done), .act_tx(act_tx), .act_rx(act_rx), .st_teof(st_teof),
  .st_reof(st_reof), .req_clk(req_clk), .act_clk(act_clk), .tx_pop(eng_tx_pop),
  .tx_empty(txf_empty), .rx_push_ok(eng_rx_push && act_rx), .rx_full(rxf_full));

// File: tb/spi_frame_master_test.sv
module spi_frame_master_test;
  logic clk = 0, rst_n = 0, tick = 0;
  logic [2:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic sck, mosi, mosi_oe, irq;

  spi_frame_master uut (.clk, .rst_n, .tick, .bus_addr, .bus_wr, .bus_rd,
    .bus_wdata, .bus_rdata, .sck, .mosi, .mosi_oe, .miso(mosi), .irq);

  always #2 clk = ~clk;
  always @(negedge clk) tick <= rst_n ? ~tick : 1'b0;

  int nchk = 0, nerr = 0;
  logic [31:0] txq[$];
  bit bitq[$];
  bit mon_cpol = 0, mon_cpha = 0;

  // bench-side slave: records mosi on the sampling edge of the chosen mode
  always @(sck) if (rst_n) begin
    if ((sck != mon_cpol) != mon_cpha) bitq.push_back(mosi);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic run_frame(input int mode, input bit lsb, input int nbits,
                           input int nwords, input bit txe, input bit rxe,
                           input bit nod, input bit ien, input bit diz);
    logic [31:0] cfg, ctl, s, v, mask, base;
    bit cpol, cpha, tedg, got;
    bit expb[$];
    cpol = mode[1]; cpha = mode[0]; tedg = ~(cpha ^ cpol);
    mask = 32'hFFFF_FFFF << (32 - nbits);
    cfg = (32'(cpol) << 30) | (32'(cpol) << 28) | (32'(tedg) << 27) |
          (32'(!tedg) << 26) | (diz ? 32'h0080_0000 : 32'h0);
    wr(0, 32'(lsb) << 24);
    wr(1, (32'(nbits-1) << 24) | (32'(nwords-1) << 16) | 32'(nod));
    wr(2, 32'(lsb) << 24);
    wr(3, (32'(nbits-1) << 24) | (32'(nwords-1) << 16));
    wr(6, ien ? 32'h0080_0080 : 32'h0);
    mon_cpol = cpol; mon_cpha = cpha;
    ctl = cfg | 32'h8000; wr(4, ctl);
    bitq.delete();
    if (diz) check(mosi_oe == 1'b0, "R11", "oe idle", 32'(mosi_oe), 0);
    if (rxe) begin ctl |= 32'h0100; wr(4, ctl); end
    if (txe) begin ctl |= 32'h0200; wr(4, ctl); end
    ctl |= 32'h4000; wr(4, ctl);
    if (diz) begin
      repeat (6) @(negedge clk);
      check(mosi_oe == 1'b1, "R11", "oe in frame", 32'(mosi_oe), 1);
      ctl &= ~32'h4000; wr(4, ctl);
      rd(4, v);
      check(v[14] == 1'b1, "R2", "fs held while busy", v, ctl | 32'h4000);
    end
    got = 0;
    for (int k = 0; k < 20000 && !got; k++) begin
      rd(5, s);
      got = (s[23] || !txe) && (s[7] || !rxe);
    end
    check(got, "R3", "frame end seen", s, 0);
    check((s & 32'h0080_0080) == ((32'(txe) << 23) | (32'(rxe) << 7)),
          "R8", "eof flags", s & 32'h0080_0080, (32'(txe) << 23) | (32'(rxe) << 7));
    check(irq == ien, "R9", "irq at end", 32'(irq), 32'(ien));
    if (diz) begin
      rd(4, v);
      check(v[14] == 1'b0, "R2", "fs clears after frame", v, ctl);
    end
    for (int w = 0; w < nwords; w++) begin
      base = (nod || !txe || w >= txq.size()) ? 32'hFFFF_FFFF : txq[w];
      for (int i = 0; i < nbits; i++)
        expb.push_back(lsb ? base[32 - nbits + i] : base[31 - i]);
      if (rxe) begin
        rd(7, v);
        check(v == (base & mask), "R4", $sformatf("rx word %0d", w), v, base & mask);
      end
    end
    check(bitq.size() == expb.size(), "R3", "bit count", bitq.size(), expb.size());
    begin
      int bad = 0;
      foreach (expb[i]) if (i < bitq.size() && bitq[i] != expb[i]) bad++;
      check(bad == 0, lsb ? "R5" : "R6", $sformatf("bit stream mode %0d", mode),
            bad, 0);
    end
    wr(5, s);
    rd(5, v);
    check((v & 32'h0080_0080) == 0, "R8", "w1c clears eof", v, 0);
    check(irq == 1'b0, "R9", "irq after clear", 32'(irq), 0);
    ctl &= ~32'h4000; wr(4, ctl);
    ctl &= ~32'h0200; wr(4, ctl);
    ctl &= ~32'h0100; wr(4, ctl);
    ctl &= ~32'h8000; wr(4, ctl);
    if (!nod && txe) repeat (nwords) if (txq.size() > 0) void'(txq.pop_front());
  endtask

  task automatic push_words(input logic [31:0] w[$]);
    foreach (w[i]) begin txq.push_back(w[i]); wr(7, w[i]); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] q[$];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(4, v); check(v == 0, "R1", "ctrl reset", v, 0);
    rd(5, v); check(v == 0, "R1", "status reset", v, 0);
    check(sck == 0 && irq == 0 && mosi_oe == 1, "R1", "pins reset",
          {29'b0, sck, irq, mosi_oe}, 32'h1);
    // R2 read-back lag of the clock enable
    wr(4, 32'h8000);
    rd(4, v); check(v[15] == 0, "R2", "clk bit not yet", v, 0);
    rd(4, v); check(v[15] == 1, "R2", "clk bit after sync", v, 32'h8000);
    wr(4, 0); @(negedge clk);
    // modes, lengths, orders
    q = {32'hA500_0000, 32'h3C00_0000, 32'hF000_0000}; push_words(q);
    run_frame(0, 0, 8, 3, 1, 1, 0, 1, 0);
    q = {32'h1234_5678, 32'h8001_0000}; push_words(q);
    run_frame(1, 1, 16, 2, 1, 1, 0, 0, 0);
    q = {32'hDEAD_BEEF, 32'h0F0F_1234}; push_words(q);
    run_frame(2, 0, 32, 2, 1, 1, 0, 1, 0);
    q = {32'hABC0_0000, 32'h5550_0000, 32'h0010_0000}; push_words(q);
    run_frame(3, 1, 12, 3, 1, 1, 0, 0, 0);
    // R7 no-data leaves FIFO word in place
    q = {32'h6900_0000}; push_words(q);
    run_frame(0, 0, 8, 2, 1, 1, 1, 0, 0);
    run_frame(0, 0, 8, 1, 1, 1, 0, 0, 0);
    // R8 receive only: no transmit end-of-frame, filler ones (R7)
    run_frame(1, 0, 10, 2, 0, 1, 0, 1, 0);
    // R10, R12 overflow and full-depth ordering
    for (int i = 0; i < 64; i++) begin
      txq.push_back(32'(i + 1) << 24); wr(7, 32'(i + 1) << 24);
    end
    wr(7, 32'hEE00_0000);
    rd(5, v); check(v[17] == 1, "R10", "overflow sticky", v, 32'h2_0000);
    wr(5, 32'h2_0000);
    rd(5, v); check(v[17] == 0, "R10", "overflow w1c", v, 0);
    run_frame(0, 0, 8, 64, 1, 1, 0, 0, 0);
    rd(7, v); check(v == 0, "R10", "empty read returns 0", v, 0);
    rd(5, v); check(v[1] == 1, "R10", "underflow sticky", v, 32'h2);
    wr(5, 32'h2);
    // R11 3-wire release and R2 delayed clear
    q = {32'h1111_2222, 32'h3333_4444, 32'h5555_6666, 32'h7777_8888}; push_words(q);
    run_frame(0, 0, 32, 4, 1, 1, 0, 0, 1);
    summary();
    $finish;
  end
endmodule